// File: doc/BRIEF.md
# ROM-Based Protocol Microsequencer

This block is a small microcoded controller that walks through a program held in an internal read-only store and turns it into timed control strobes for a link-protocol engine. Everything runs on one system clock. Two clock enables are derived from it. A fetch enable fires every fourth cycle and advances the program counter. An execution enable fires every eighth cycle and paces decoding and execution.

Each instruction is two bytes: an opcode byte followed by an immediate byte. The two bytes are fetched into separate registers on consecutive fetch enables. The opcode is decoded in one execution period and the instruction is carried out in the next. The instruction set has three operations:
- A strobe pulses the immediate byte onto the control outputs.
- A delay stalls the program counter for a number of execution periods.
- A jump reloads the program counter from bits taken out of the instruction.

An external reconfiguration timeout aborts whatever is in progress, restarts the program at address zero and sets a sticky status flag. The flag stays set until a clear pulse arrives.

The store holds a short built-in test program. The protocol datapath is not part of the block.

Top module: `recon_microseq`

## Requirements
- R1: While reset is low, and right after it is released, `ctrl_strobe_o` is 0 and `recon_flag_o` is 0. The first strobe appears 24 system cycles after the first rising edge with reset high, counting that edge as cycle 1.
- R2: The program counter changes only on every fourth system cycle, or on a timeout. The execution steps happen only on every eighth cycle. A strobe-only instruction therefore spans exactly 24 cycles from one strobe to the next instruction's start.
- R3: An opcode with bits [7:6] = 2'b01 drives the following immediate byte onto `ctrl_strobe_o` for exactly one system cycle.
- R4: An opcode with bits [7:6] = 2'b00 is a delay. The program counter holds for (immediate × 8) extra cycles, and no strobe is issued during the delay.
- R5: An opcode with bits [7:6] = 2'b10 is a jump. The next instruction is fetched from the 10-bit address {opcode[1:0], immediate}.
- R6: The program counter never exceeds 543. Stepping past address 543 continues at address 0.
- R7: A high `recon_timeout_i` at a clock edge clears the program counter to 0, cancels any pending strobe or delay, and restarts fetching at the next fetch enable. A timeout seen on the edge just after a strobe produces the strobe of address 0 (0xA5) 24 cycles later. While the timeout is held high, no strobe is issued.
- R8: `recon_flag_o` becomes 1 on the edge that samples a timeout. It stays 1 until `clear_flags_i` is sampled high with no timeout in the same cycle; if both are high, the flag is set. Only a timeout can set the flag.
- R9: The built-in program issues strobes 0xA5, 0x3C and 0x81 in a repeating cycle. The gaps between them are 72, 48 and 24 system cycles. The program uses a delay of 3 periods at address 2, a jump from address 6 to address 542, and wrap-around from 543 back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| recon_timeout_i | input | 1 | Reconfiguration timeout; restarts the program |
| clear_flags_i | input | 1 | Clears the sticky timeout flag |
| recon_flag_o | output | 1 | Sticky timeout status flag |
| ctrl_strobe_o | output | 8 | Decoded control strobes, one-cycle pulse |

## Verification
The main function is exercised with three patterns:
- A free run of the built-in program measures the cycle gaps between strobes. The 72-cycle gap separates a working delay loop from a zero-length one. The 48-cycle gap shows that the jump really skips ahead. The 24-cycle gap after the jump shows that address 543 wraps to 0.
- A single-cycle timeout given right after a strobe tells a true restart at address 0 (0xA5 after 24 cycles) apart from normal continuation (0x3C after 72 cycles).
- A timeout held for many cycles shows that the sequencer stays parked.

Pulses of clear alone, of clear together with timeout, and of reset with the flag set separate the priorities of the sticky flag.

// File: rtl/microseq_pkg.sv
// Package: shared types and helpers for the protocol microsequencer.
// Assumes 8-bit instruction bytes with the operation class in bits [7:6].
package microseq_pkg;

    // Operation class decoded from opcode bits [7:6]
    typedef enum logic [1:0] {
        K_DELAY  = 2'b00,
        K_STROBE = 2'b01,
        K_JUMP   = 2'b10,
        K_SKIP   = 2'b11
    } op_kind_t;

    // Sequencer phases: two fetches, decode, execute, delay wait
    typedef enum logic [2:0] {
        ST_FETCH_OP,
        ST_FETCH_IMM,
        ST_DECODE,
        ST_EXECUTE,
        ST_WAIT
    } seq_state_t;

    localparam logic [7:0] OPB_DELAY  = 8'h00;
    localparam logic [7:0] OPB_STROBE = 8'h40;
    localparam logic [7:0] OPB_JUMP   = 8'h80;

    // Map an opcode byte to its operation class
    function automatic op_kind_t classify(input logic [7:0] op);
        return op_kind_t'(op[7:6]);
    endfunction

endpackage

// File: rtl/microseq_clkdiv.sv
// Clock-enable generator: derives the fetch enable (every PC_DIV cycles)
// and the execution enable (every EX_DIV cycles) from one free-running
// counter. Assumes both divisors are powers of two and PC_DIV < EX_DIV,
// so every execution enable coincides with a fetch enable.
module microseq_clkdiv #(
    parameter int PC_DIV = 4,
    parameter int EX_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic pc_tick,
    output logic ex_tick
);
    localparam int CW = $clog2(EX_DIV);
    localparam int PW = $clog2(PC_DIV);

    logic [CW-1:0] div_q;

    // Free-running phase counter, zeroed by reset
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    // Enables fire in the last phase of each divided period
    always_comb begin
        pc_tick = (div_q[PW-1:0] == {PW{1'b1}});
        ex_tick = (div_q == {CW{1'b1}});
    end
endmodule

// File: rtl/microseq_rom.sv
// Program store: ROM_DEPTH words of DATA_W bits, read combinationally.
// Holds a built-in test program; every other word reads as a zero-length
// delay. Assumes PC_W bits address the whole store and PC_W > DATA_W.
module microseq_rom
    import microseq_pkg::*;
#(
    parameter int ROM_DEPTH = 544,
    parameter int PC_W      = 10,
    parameter int DATA_W    = 8
) (
    input  logic [PC_W-1:0]   addr,
    output logic [DATA_W-1:0] data
);
    // The tail instruction sits in the last two words of the store
    localparam int            TAIL_I = ROM_DEPTH - 2;
    localparam logic [PC_W-1:0] TAIL_A = PC_W'(TAIL_I);
    localparam logic [DATA_W-1:0] JMP_OP  = DATA_W'(OPB_JUMP) | DATA_W'(TAIL_A >> DATA_W);
    localparam logic [DATA_W-1:0] JMP_IMM = TAIL_A[DATA_W-1:0];

    // Address decode of the test program
    always_comb begin
        data = '0;
        if (addr == PC_W'(0))          data = DATA_W'(OPB_STROBE);
        else if (addr == PC_W'(1))     data = DATA_W'(8'hA5);
        else if (addr == PC_W'(2))     data = DATA_W'(OPB_DELAY);
        else if (addr == PC_W'(3))     data = DATA_W'(8'h03);
        else if (addr == PC_W'(4))     data = DATA_W'(OPB_STROBE);
        else if (addr == PC_W'(5))     data = DATA_W'(8'h3C);
        else if (addr == PC_W'(6))     data = JMP_OP;
        else if (addr == PC_W'(7))     data = JMP_IMM;
        else if (addr == TAIL_A)       data = DATA_W'(OPB_STROBE);
        else if (addr == TAIL_A + 1'b1) data = DATA_W'(8'h81);
    end
endmodule

// File: rtl/microseq_core.sv
// Sequencer core: program counter, opcode and immediate registers,
// registered decode, execution and the delay loop. A timeout has priority
// over every other action. Assumes the enables come from microseq_clkdiv.
module microseq_core
    import microseq_pkg::*;
#(
    parameter int ROM_DEPTH = 544,
    parameter int PC_W      = 10,
    parameter int DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pc_tick,
    input  logic              ex_tick,
    input  logic              timeout,
    input  logic [DATA_W-1:0] rom_data,
    output logic [PC_W-1:0]   pc,
    output logic [DATA_W-1:0] strobe,
    output logic              waiting
);
    localparam int HI_W = PC_W - DATA_W;

    seq_state_t        state_q;
    op_kind_t          kind_q;
    logic [PC_W-1:0]   pc_q;
    logic [DATA_W-1:0] op_q;
    logic [DATA_W-1:0] imm_q;
    logic [DATA_W-1:0] delay_q;
    logic [DATA_W-1:0] strobe_q;
    logic [PC_W-1:0]   pc_inc;
    logic [PC_W-1:0]   jump_tgt;

    // Wrap an address that falls outside the store back to zero
    function automatic logic [PC_W-1:0] wrap_addr(input logic [PC_W:0] a);
        return (a >= (PC_W+1)'(ROM_DEPTH)) ? '0 : a[PC_W-1:0];
    endfunction

    // Next sequential address and jump target
    always_comb begin
        pc_inc   = wrap_addr({1'b0, pc_q} + (PC_W+1)'(1));
        jump_tgt = wrap_addr({1'b0, op_q[HI_W-1:0], imm_q});
    end

    // Fetch, decode, execute and delay state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_FETCH_OP;
            kind_q   <= K_DELAY;
            pc_q     <= '0;
            op_q     <= '0;
            imm_q    <= '0;
            delay_q  <= '0;
            strobe_q <= '0;
        end else if (timeout) begin
            state_q  <= ST_FETCH_OP;
            pc_q     <= '0;
            delay_q  <= '0;
            strobe_q <= '0;
        end else begin
            strobe_q <= '0;
            case (state_q)
                ST_FETCH_OP: if (pc_tick) begin
                    op_q    <= rom_data;
                    pc_q    <= pc_inc;
                    state_q <= ST_FETCH_IMM;
                end
                ST_FETCH_IMM: if (pc_tick) begin
                    imm_q   <= rom_data;
                    pc_q    <= pc_inc;
                    state_q <= ST_DECODE;
                end
                ST_DECODE: if (ex_tick) begin
                    kind_q  <= classify(op_q);
                    state_q <= ST_EXECUTE;
                end
                ST_EXECUTE: if (ex_tick) begin
                    state_q <= ST_FETCH_OP;
                    case (kind_q)
                        K_STROBE: strobe_q <= imm_q;
                        K_JUMP:   pc_q     <= jump_tgt;
                        K_DELAY: if (imm_q != '0) begin
                            delay_q <= imm_q;
                            state_q <= ST_WAIT;
                        end
                        default: ;
                    endcase
                end
                ST_WAIT: if (ex_tick) begin
                    delay_q <= delay_q - 1'b1;
                    if (delay_q == DATA_W'(1)) state_q <= ST_FETCH_OP;
                end
                default: state_q <= ST_FETCH_OP;
            endcase
        end
    end

    // Outputs towards the top level
    always_comb begin
        pc      = pc_q;
        strobe  = strobe_q;
        waiting = (state_q == ST_WAIT);
    end
endmodule

// File: rtl/recon_microseq.sv
// Top level of the protocol microsequencer: ties the enable generator,
// program store and sequencer core together and keeps the sticky
// timeout flag. Single clock domain, synchronous active-low reset.
module recon_microseq #(
    parameter int ROM_DEPTH = 544,
    parameter int PC_W      = 10,
    parameter int DATA_W    = 8,
    parameter int PC_DIV    = 4,
    parameter int EX_DIV    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              recon_timeout_i,
    input  logic              clear_flags_i,
    output logic              recon_flag_o,
    output logic [DATA_W-1:0] ctrl_strobe_o
);
    logic              pc_tick;
    logic              ex_tick;
    logic              waiting;
    logic [PC_W-1:0]   pc;
    logic [DATA_W-1:0] rom_data;
    logic              flag_q;

    microseq_clkdiv #(.PC_DIV(PC_DIV), .EX_DIV(EX_DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .pc_tick(pc_tick), .ex_tick(ex_tick)
    );

    microseq_rom #(.ROM_DEPTH(ROM_DEPTH), .PC_W(PC_W), .DATA_W(DATA_W)) u_rom (
        .addr(pc), .data(rom_data)
    );

    microseq_core #(.ROM_DEPTH(ROM_DEPTH), .PC_W(PC_W), .DATA_W(DATA_W)) u_core (
        .clk(clk), .rst_n(rst_n), .pc_tick(pc_tick), .ex_tick(ex_tick),
        .timeout(recon_timeout_i), .rom_data(rom_data), .pc(pc),
        .strobe(ctrl_strobe_o), .waiting(waiting)
    );

    // Sticky timeout flag: set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n)               flag_q <= 1'b0;
        else if (recon_timeout_i) flag_q <= 1'b1;
        else if (clear_flags_i)   flag_q <= 1'b0;
    end

    assign recon_flag_o = flag_q;
endmodule

// File: rtl/microseq_chk.sv
// Checker for recon_microseq: temporal properties on ports and on the
// signals between the enable generator and the core. Attached by bind.
module microseq_chk #(
    parameter int ROM_DEPTH = 544,
    parameter int PC_W      = 10,
    parameter int DATA_W    = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tmo,
    input logic              clr,
    input logic              flag,
    input logic [DATA_W-1:0] strobe,
    input logic [PC_W-1:0]   pc,
    input logic              pc_tick,
    input logic              waiting
);
    localparam logic [PC_W-1:0] LAST = PC_W'(ROM_DEPTH - 1);

    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe != '0) |=> (strobe == '0)); // R3
    AST_PC_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_tick && !tmo) |=> $stable(pc)); // R2
    AST_DELAY_FREEZES_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && !tmo) |=> $stable(pc)); // R4
    AST_PC_IN_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        pc <= LAST); // R6
    AST_TIMEOUT_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        tmo |=> (pc == '0 && strobe == '0)); // R7
    AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        tmo |=> flag); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag); // R8
    AST_FLAG_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !tmo) |=> !flag); // R8
endmodule

bind recon_microseq microseq_chk #(.ROM_DEPTH(ROM_DEPTH), .PC_W(PC_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tmo(recon_timeout_i), .clr(clear_flags_i),
    .flag(recon_flag_o), .strobe(ctrl_strobe_o), .pc(pc),
    .pc_tick(pc_tick), .waiting(waiting)
);

// File: tb/tb_recon_microseq.sv
`timescale 1ns/1ps
// Directed bench for recon_microseq: one task per scenario.
module tb_recon_microseq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tmo = 1'b0;
    logic       clr = 1'b0;
    logic       flag;
    logic [7:0] strobe;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    recon_microseq dut (
        .clk(clk), .rst_n(rst_n), .recon_timeout_i(tmo), .clear_flags_i(clr),
        .recon_flag_o(flag), .ctrl_strobe_o(strobe)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count rising edges until a strobe is seen at a falling edge
    task automatic wait_strobe(output int n, output logic [7:0] v);
        n = 0;
        do begin
            @(posedge clk); n++;
            @(negedge clk);
        end while (strobe == 8'h00 && n < 2000);
        v = strobe;
    endtask

    task automatic t_reset;
        int n; logic [7:0] v;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 strobe in reset", int'(strobe), 0);
        check("R1 flag in reset", int'(flag), 0);
        rst_n = 1'b1;
        wait_strobe(n, v);
        check("R1 first strobe delay", n, 24);
        check("R9 first strobe value", int'(v), 'hA5);
    endtask

    task automatic t_sequence;
        int n; logic [7:0] v;
        wait_strobe(n, v);
        check("R4 delay gap", n, 72);
        check("R9 second value", int'(v), 'h3C);
        wait_strobe(n, v);
        check("R5 jump gap", n, 48);
        check("R5 jump target value", int'(v), 'h81);
        wait_strobe(n, v);
        check("R6 wrap gap", n, 24);
        check("R6 wrap value", int'(v), 'hA5);
        wait_strobe(n, v);
        check("R2 repeat gap", n, 72);
        check("R3 repeat value", int'(v), 'h3C);
        @(negedge clk);
        check("R3 strobe one cycle", int'(strobe), 0);
    endtask

    task automatic t_timeout;
        int n; logic [7:0] v;
        wait_strobe(n, v);
        check("R9 pre-timeout value", int'(v), 'h81);
        wait_strobe(n, v);
        check("R9 pre-timeout A5", int'(v), 'hA5);
        tmo = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tmo = 1'b0;
        check("R8 flag set", int'(flag), 1);
        check("R7 no strobe after timeout", int'(strobe), 0);
        wait_strobe(n, v);
        check("R7 restart delay", n, 23);
        check("R7 restart value", int'(v), 'hA5);
        check("R8 flag sticky", int'(flag), 1);
    endtask

    task automatic t_held;
        int n; int seen = 0; logic [7:0] v;
        tmo = 1'b1;
        repeat (60) begin
            @(negedge clk);
            if (strobe != 8'h00) seen++;
        end
        tmo = 1'b0;
        check("R7 quiet while held", seen, 0);
        wait_strobe(n, v);
        check("R7 value after release", int'(v), 'hA5);
        check("R7 release delay bound", int'(n <= 24), 1);
    endtask

    task automatic t_clear;
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        check("R8 clear", int'(flag), 0);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        check("R8 clear when clear", int'(flag), 0);
        repeat (5) @(negedge clk);
        check("R8 stays clear", int'(flag), 0);
        clr = 1'b1; tmo = 1'b1;
        @(negedge clk);
        clr = 1'b0; tmo = 1'b0;
        check("R8 set beats clear", int'(flag), 1);
    endtask

    task automatic t_reset_flag;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears flag", int'(flag), 0);
        check("R1 reset clears strobe", int'(strobe), 0);
    endtask

    initial begin
        t_reset();
        t_sequence();
        t_timeout();
        t_held();
        t_clear();
        t_reset_flag();
        t_reset();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule